// File: doc/BRIEF.md
# Calendar Clock Timer with Alarm

This block keeps wall-clock time in a low-speed clock domain. Each one-cycle pulse on `tick_i` arrives at 256 Hz, derived from a 32.768 kHz oscillator, and advances an 8-bit binary prescaler while the timer is running. The prescaler's bits provide taps from 128 Hz down to 1 Hz. Each time the prescaler wraps, a cascade of counters advances: seconds (6 bits), minutes (6 bits), hours (5 bits) and a 16-bit day count.

A flat register interface gives software access to the block. Reads are combinational. Writes take effect on the clock edge. Software can read every counter. It can load the time counters only while the timer is stopped. It also sets the alarm comparison values and the interrupt enables, and it clears event flags by writing ones.

A single request line is the OR of the enabled flags. Ten event sources can set these flags: four prescaler taps, three rollover events and three alarm matches.

Top module: `rtc_alarm_timer`

Register addresses:

| Address | Contents |
|---|---|
| 0 | Control. Bit 0 is run and reads back. Writing 1 to bit 1 is a one-shot clear. |
| 1 | Prescaler, read-only. |
| 2 | Seconds. |
| 3 | Minutes. |
| 4 | Hours. |
| 5 | Day. |
| 6 | Interrupt enables. |
| 7 | Event flags. |
| 8 | Minute alarm value. |
| 9 | Hour alarm value. |
| 10 | Day alarm value. |

Flag and enable bit positions:

| Bit | Event |
|---|---|
| 0 | 32 Hz tap |
| 1 | 8 Hz tap |
| 2 | 2 Hz tap |
| 3 | 1 Hz tap |
| 4 | Minute rollover |
| 5 | Hour rollover |
| 6 | Day rollover |
| 7 | Minute alarm |
| 8 | Hour alarm |
| 9 | Day alarm |

## Requirements
- R1: After reset, every readable register (addresses 0 to 10) reads 0 and `irq_o` is low.
- R2: The prescaler advances by one on each cycle with `tick_i` high while run (control bit 0) is set. When run is clear, the prescaler holds its value.
- R3: Seconds advance when the prescaler wraps from 255 to 0. Seconds wrap from 59 to 0, and that wrap increments minutes.
- R4: Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the day count. The day count wraps from 65535 to 0.
- R5: Writes to the seconds, minutes, hours and day registers take effect only while run is clear. While running, such writes are ignored.
- R6: Writing control bit 1 as 1 clears the prescaler and seconds. It leaves minutes, hours and day unchanged. Control bit 0 of the same write sets run.
- R7: Flags 0 to 3 set on the 0-to-1 transition of prescaler bits 2, 4, 6 and 7 respectively (32, 8, 2 and 1 Hz).
- R8: Flag 4 sets on a seconds wrap, flag 5 on a minutes wrap and flag 6 on an hours wrap.
- R9: Flags 7, 8 and 9 set one cycle after a comparison becomes true. These compare minutes with the minute alarm value (address 8), hours with the hour alarm value (address 9), and the low 5 bits of the day count with the day alarm value (address 10). The upper day bits take no part in the comparison.
- R10: Writing to the flag register clears each flag whose data bit is 1 and leaves the others set. A new event in the same cycle takes priority over the clear.
- R11: `irq_o` is high exactly when some flag is set while its enable bit at address 6 (same bit position) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Low-speed clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 256 Hz enable pulse |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
A miscounted prescaler appears on the prescaler register and the tap flags. It also shifts every seconds carry by up to 256 ticks, so the next seconds read shows it.

A bad wrap limit or a missing carry shows in the same cycle as the wrap: one counter stops at a wrong value, or the next counter stays unchanged. The rollover flag also fails to rise.

Alarm comparison faults show one cycle after the counter write or carry, as a missing or spurious flag. The request pin then follows that flag through its enable in the same cycle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned PRE_W    = 8;
  localparam int unsigned SEC_W    = 6;
  localparam int unsigned MIN_W    = 6;
  localparam int unsigned HR_W     = 5;
  localparam int unsigned DAY_W    = 16;
  localparam int unsigned ADAY_W   = 5;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned N_TAP    = 4;
  localparam int unsigned N_FLAG   = 10;

  localparam int unsigned SEC_MAX  = 59;
  localparam int unsigned MIN_MAX  = 59;
  localparam int unsigned HR_MAX   = 23;
  localparam int unsigned DAY_MAX  = (1 << DAY_W) - 1;

  // prescaler bits for the 32, 8, 2, 1 Hz taps
  localparam int unsigned TAP_BIT [N_TAP] = '{2, 4, 6, 7};

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 4'd0,
    A_PRESC = 4'd1,
    A_SEC   = 4'd2,
    A_MIN   = 4'd3,
    A_HR    = 4'd4,
    A_DAY   = 4'd5,
    A_IEN   = 4'd6,
    A_FLAG  = 4'd7,
    A_AMIN  = 4'd8,
    A_AHR   = 4'd9,
    A_ADAY  = 4'd10
  } reg_addr_e;

  localparam int unsigned F_ROLL_MIN = 4;
  localparam int unsigned F_ROLL_HR  = 5;
  localparam int unsigned F_ROLL_DAY = 6;
  localparam int unsigned F_ALM_MIN  = 7;
  localparam int unsigned F_ALM_HR   = 8;
  localparam int unsigned F_ALM_DAY  = 9;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] rise_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_inc;

  assign cnt_inc = cnt_q + W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (adv_i)  cnt_q <= cnt_inc;
  end

  always_comb begin
    rise_o = '0;
    wrap_o = 1'b0;
    if (adv_i && !clr_i) begin
      rise_o = ~cnt_q & cnt_inc;
      wrap_o = &cnt_q;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rtc_wrap_cnt.sv
module rtc_wrap_cnt #(
  parameter int unsigned W   = 6,
  parameter int unsigned MAX = 59
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         carry_o
);
  localparam logic [W-1:0] LIMIT = W'(MAX);

  logic [W-1:0] cnt_q;
  logic         at_limit;

  // >= so an out-of-range load still wraps
  assign at_limit = (cnt_q >= LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (wr_i)     cnt_q <= wdata_i;
    else if (inc_i)    cnt_q <= at_limit ? '0 : cnt_q + W'(1);
  end

  assign carry_o = inc_i && !clr_i && !wr_i && at_limit;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] ref_i,
  output logic         hit_o
);
  logic match, match_q;

  assign match = (cnt_i == ref_i);

  // reset high: power-on equality is not an alarm
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) match_q <= 1'b1;
    else         match_q <= match;
  end

  assign hit_o = match && !match_q;
endmodule

// File: rtl/rtc_evt_flags.sv
module rtc_evt_flags #(
  parameter int unsigned N = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] flags_o,
  output logic         irq_o
);
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_q[i] <= 1'b0;
      else if (set_i[i])  flag_q[i] <= 1'b1;
      else if (clr_i[i])  flag_q[i] <= 1'b0;
    end
  end

  assign flags_o = flag_q;
  assign irq_o   = |(flag_q & en_i);
endmodule

// File: rtl/rtc_alarm_timer.sv
module rtc_alarm_timer
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic              run_q;
  logic              ctrl_wr, soft_clr, adv, cnt_wr;
  logic [PRE_W-1:0]  presc, presc_rise;
  logic              presc_wrap;
  logic [SEC_W-1:0]  sec_q;
  logic [MIN_W-1:0]  min_q;
  logic [HR_W-1:0]   hr_q;
  logic [DAY_W-1:0]  day_q;
  logic              sec_carry, min_carry, hr_carry, day_carry;
  logic [MIN_W-1:0]  alm_min_q;
  logic [HR_W-1:0]   alm_hr_q;
  logic [ADAY_W-1:0] alm_day_q;
  logic [N_FLAG-1:0] ien_q, flags, evt_set, flag_w1c;
  logic              hit_min, hit_hr, hit_day;

  assign ctrl_wr  = we_i && (addr_i == A_CTRL);
  assign soft_clr = ctrl_wr && wdata_i[1];
  assign adv      = run_q && tick_i;
  assign cnt_wr   = we_i && !run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      ien_q     <= '0;
      alm_min_q <= '0;
      alm_hr_q  <= '0;
      alm_day_q <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        A_CTRL: run_q     <= wdata_i[0];
        A_IEN:  ien_q     <= wdata_i[N_FLAG-1:0];
        A_AMIN: alm_min_q <= wdata_i[MIN_W-1:0];
        A_AHR:  alm_hr_q  <= wdata_i[HR_W-1:0];
        A_ADAY: alm_day_q <= wdata_i[ADAY_W-1:0];
        default: ;
      endcase
    end
  end

  rtc_prescaler #(.W(PRE_W)) u_presc (
    .clk_i, .rst_ni, .adv_i(adv), .clr_i(soft_clr),
    .cnt_o(presc), .rise_o(presc_rise), .wrap_o(presc_wrap)
  );

  rtc_wrap_cnt #(.W(SEC_W), .MAX(SEC_MAX)) u_sec (
    .clk_i, .rst_ni, .clr_i(soft_clr),
    .wr_i(cnt_wr && addr_i == A_SEC), .wdata_i(wdata_i[SEC_W-1:0]),
    .inc_i(presc_wrap), .cnt_o(sec_q), .carry_o(sec_carry)
  );

  rtc_wrap_cnt #(.W(MIN_W), .MAX(MIN_MAX)) u_min (
    .clk_i, .rst_ni, .clr_i(1'b0),
    .wr_i(cnt_wr && addr_i == A_MIN), .wdata_i(wdata_i[MIN_W-1:0]),
    .inc_i(sec_carry), .cnt_o(min_q), .carry_o(min_carry)
  );

  rtc_wrap_cnt #(.W(HR_W), .MAX(HR_MAX)) u_hr (
    .clk_i, .rst_ni, .clr_i(1'b0),
    .wr_i(cnt_wr && addr_i == A_HR), .wdata_i(wdata_i[HR_W-1:0]),
    .inc_i(min_carry), .cnt_o(hr_q), .carry_o(hr_carry)
  );

  rtc_wrap_cnt #(.W(DAY_W), .MAX(DAY_MAX)) u_day (
    .clk_i, .rst_ni, .clr_i(1'b0),
    .wr_i(cnt_wr && addr_i == A_DAY), .wdata_i(wdata_i[DAY_W-1:0]),
    .inc_i(hr_carry), .cnt_o(day_q), .carry_o(day_carry)
  );

  rtc_alarm_cmp #(.W(MIN_W)) u_alm_min (
    .clk_i, .rst_ni, .cnt_i(min_q), .ref_i(alm_min_q), .hit_o(hit_min)
  );

  rtc_alarm_cmp #(.W(HR_W)) u_alm_hr (
    .clk_i, .rst_ni, .cnt_i(hr_q), .ref_i(alm_hr_q), .hit_o(hit_hr)
  );

  rtc_alarm_cmp #(.W(ADAY_W)) u_alm_day (
    .clk_i, .rst_ni, .cnt_i(day_q[ADAY_W-1:0]), .ref_i(alm_day_q), .hit_o(hit_day)
  );

  for (genvar t = 0; t < N_TAP; t++) begin : g_tap
    assign evt_set[t] = presc_rise[TAP_BIT[t]];
  end
  assign evt_set[F_ROLL_MIN] = sec_carry;
  assign evt_set[F_ROLL_HR]  = min_carry;
  assign evt_set[F_ROLL_DAY] = hr_carry;
  assign evt_set[F_ALM_MIN]  = hit_min;
  assign evt_set[F_ALM_HR]   = hit_hr;
  assign evt_set[F_ALM_DAY]  = hit_day;

  assign flag_w1c = (we_i && addr_i == A_FLAG) ? wdata_i[N_FLAG-1:0] : '0;

  rtc_evt_flags #(.N(N_FLAG)) u_flags (
    .clk_i, .rst_ni, .set_i(evt_set), .clr_i(flag_w1c), .en_i(ien_q),
    .flags_o(flags), .irq_o(irq_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL:  rdata_o = DATA_W'(run_q);
      A_PRESC: rdata_o = DATA_W'(presc);
      A_SEC:   rdata_o = DATA_W'(sec_q);
      A_MIN:   rdata_o = DATA_W'(min_q);
      A_HR:    rdata_o = DATA_W'(hr_q);
      A_DAY:   rdata_o = day_q;
      A_IEN:   rdata_o = DATA_W'(ien_q);
      A_FLAG:  rdata_o = DATA_W'(flags);
      A_AMIN:  rdata_o = DATA_W'(alm_min_q);
      A_AHR:   rdata_o = DATA_W'(alm_hr_q);
      A_ADAY:  rdata_o = DATA_W'(alm_day_q);
      default: rdata_o = '0;
    endcase
  end

  logic unused_carry;
  assign unused_carry = day_carry;
endmodule

// File: rtl/rtc_alarm_timer_chk.sv
module rtc_alarm_timer_chk
  import rtc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              run_q,
  input logic [PRE_W-1:0]  presc,
  input logic [SEC_W-1:0]  sec,
  input logic [N_FLAG-1:0] ien,
  input logic [N_FLAG-1:0] flags,
  input logic [N_FLAG-1:0] evt_set,
  input logic              irq_o
);
  // R2
  presc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !(we_i && addr_i == A_CTRL)) |=> $stable(presc));

  // R3
  sec_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && tick_i && presc == '1 && sec == SEC_W'(SEC_MAX)) |=> (sec == '0));

  // R5
  sec_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && we_i && addr_i == A_SEC && !tick_i) |=> $stable(sec));

  // R6
  soft_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_CTRL && wdata_i[1]) |=> (presc == '0 && sec == '0));

  // R10
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_FLAG && &wdata_i[N_FLAG-1:0] && evt_set == '0) |=> (flags == '0));

  // R11
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien == '0) |-> !irq_o);
endmodule

bind rtc_alarm_timer rtc_alarm_timer_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .we_i(we_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .run_q(run_q), .presc(presc),
  .sec(sec_q), .ien(ien_q), .flags(flags), .evt_set(evt_set), .irq_o(irq_o)
);

// File: tb/rtc_alarm_timer_bench.sv
module rtc_alarm_timer_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  rtc_alarm_timer u_rtc_alarm_timer (
    .clk_i, .rst_ni, .tick_i, .we_i, .addr_i, .wdata_i, .rdata_o, .irq_o
  );

  always #5 clk_i = ~clk_i;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = 4'(a); wdata_i = 16'(d);
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk_i);
    addr_i = 4'(a);
    #1 d = int'(rdata_o);
  endtask

  task automatic chk_reg(string req, int a, int exp);
    int d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic ticks(int n);
    @(negedge clk_i);
    tick_i = 1'b1;
    repeat (n) @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic t_reset;
    for (int a = 0; a <= 10; a++) chk_reg("R1", a, 0);
    check("R1 irq", int'(irq_o), 0);
  endtask

  task automatic t_prescale;
    ticks(10);
    chk_reg("R2 stopped", 1, 0);
    wr(0, 1);
    ticks(10);
    chk_reg("R2 run", 1, 10);
    wr(0, 0);
    ticks(5);
    chk_reg("R2 hold", 1, 10);
  endtask

  task automatic t_taps;
    wr(0, 3);
    chk_reg("R6 run bit", 0, 1);
    wr(7, 16'h3ff);
    ticks(4);
    chk_reg("R7 32Hz", 7, 16'h001);
    wr(7, 16'h3ff);
    ticks(12);
    chk_reg("R7 8Hz", 7, 16'h003);
    wr(7, 16'h3ff);
    ticks(48);
    chk_reg("R7 2Hz", 7, 16'h007);
    wr(7, 16'h3ff);
    ticks(64);
    chk_reg("R7 1Hz", 7, 16'h00b);
  endtask

  task automatic t_cascade;
    int d;
    ticks(128);
    chk_reg("R3 sec step", 2, 1);
    chk_reg("R3 presc wrap", 1, 0);
    wr(0, 0);
    wr(2, 59); wr(3, 59); wr(4, 23); wr(5, 16'hffff);
    wr(7, 16'h3ff);
    wr(0, 1);
    ticks(256);
    chk_reg("R3 sec wrap", 2, 0);
    chk_reg("R4 min wrap", 3, 0);
    chk_reg("R4 hour wrap", 4, 0);
    chk_reg("R4 day wrap", 5, 0);
    rd(7, d);
    check("R8 rollover flags", d & 16'h070, 16'h070);
    wr(0, 0);
    wr(2, 59); wr(3, 10);
    wr(7, 16'h3ff);
    wr(0, 1);
    ticks(256);
    chk_reg("R3 carry to min", 3, 11);
    chk_reg("R4 hour kept", 4, 0);
    rd(7, d);
    check("R8 only min roll", d & 16'h070, 16'h010);
  endtask

  task automatic t_lock;
    wr(2, 5);
    chk_reg("R5 ignored while running", 2, 0);
    wr(0, 0);
    wr(2, 5);
    chk_reg("R5 accepted while stopped", 2, 5);
  endtask

  task automatic t_softclr;
    wr(3, 7);
    wr(0, 1);
    ticks(3);
    wr(0, 2);
    chk_reg("R6 presc", 1, 0);
    chk_reg("R6 sec", 2, 0);
    chk_reg("R6 min kept", 3, 7);
    chk_reg("R6 stopped", 0, 0);
  endtask

  task automatic t_alarm;
    int d;
    wr(8, 8);
    wr(2, 59);
    wr(7, 16'h3ff);
    wr(0, 1);
    ticks(256);
    chk_reg("R9 min reached", 3, 8);
    rd(7, d);
    check("R9 min alarm", (d >> 7) & 1, 1);
    wr(0, 0);
    wr(9, 5);
    wr(10, 4);
    wr(5, 16'h0023);
    wr(7, 16'h3ff);
    rd(7, d);
    check("R9 day no match", (d >> 9) & 1, 0);
    wr(5, 16'h0024);
    rd(7, d);
    check("R9 day low bits", (d >> 9) & 1, 1);
    wr(4, 5);
    rd(7, d);
    check("R9 hour alarm", (d >> 8) & 1, 1);
  endtask

  task automatic t_irq;
    int d;
    wr(6, 0);
    check("R11 masked", int'(irq_o), 0);
    wr(6, 16'h200);
    check("R11 enabled", int'(irq_o), 1);
    wr(7, 16'h200);
    check("R11 cleared", int'(irq_o), 0);
    rd(7, d);
    check("R10 other flag kept", (d >> 8) & 3, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset;
    t_prescale;
    t_taps;
    t_cascade;
    t_lock;
    t_softclr;
    t_alarm;
    t_irq;
    done = 1;
  end

  initial begin
    for (int i = 0; i < 50000 && !done; i++) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule